// File: doc/BRIEF.md
# Half-integer clock divider branch

This block is one branch of a clock tree. It picks one of several incoming source clocks, passes the chosen clock through an enable gate, and divides the result by a ratio of the form (2v+3)/2. With v = 0 the ratio is 1.5, with v = 1 it is 2.5, and so on up to the largest value the field can hold. The divider counts on both edges of its input clock, so output edges can fall on half-cycle boundaries. The high phase is one input half-period longer than the low phase, which keeps the duty cycle close to 50%.

Software drives two 32-bit registers through a small write port and can read them back through a combinational read port. Address 0 holds the divider field and the source select. Address 1 holds the gate enable. By default a write carries its own bit mask in the upper halfword, so one field can change without a read-modify-write.

The select logic, the gate and the divider each sit in their own clock domain. Each is built so that no runt pulse or shortened phase reaches the output when software changes a setting while the clock is running. Parameters can remove the gate, the divider or the mux, and can make the select field fixed.

Top module: `hdiv_branch`

## Requirements
- R1: After reset both registers read 0. That means source 0 is selected, the ratio is 1.5 and the gate is off, and `clk_out` makes no edge while the gate stays off.
- R2: With divider field v in bits [3:0] of the register at address 0, the period of `clk_out` is (2v+3)/2 periods of the selected source, for every v from 0 to 15.
- R3: Each high phase of `clk_out` lasts v+2 half-periods of the selected source, and each low phase lasts v+1 half-periods.
- R4: `wr_addr` 0 selects the control register and `wr_addr` 1 selects the gate register. A write changes a lower-half bit b only when `wr_data[b+16]` is 1, and every other bit keeps its value. A read returns the stored fields at their bit positions and 0 in all unused bits.
- R5: The source select in bit 8 of the control register chooses the `src_clk` index that drives the branch.
- R6: The gate enable sits in bit 3 of the gate register, with its mask in bit 19. When the enable is 0, `clk_out` holds still. When it is 1, `clk_out` runs.
- R7: No pulse on `clk_out` is shorter than the shortest legal phase. This holds across source switches, gate changes and ratio changes. At most one source is enabled into the mux at any time.
- R8: A new divider value takes effect only at an output period boundary. While the ratio changes, every observed period equals either the old period or the new one.
- R9: When the select field is configured as read-only, writes to bit 8 are ignored and the field reads 0. The divider field in the same register still accepts writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 gate |
| wr_data | input | 32 | Write data; upper halfword is the bit mask in masked mode |
| rd_addr | input | 1 | Read address: 0 control, 1 gate |
| rd_data | output | 32 | Read data of the addressed register |
| src_clk | input | NUM_SRC | Source clocks |
| clk_out | output | 1 | Divided branch clock |

## Verification
The hardest situation to reach is a divider value that changes while the output is running. The new value must wait for the end of a divider cycle, and the only evidence at the ports is the sequence of output periods. The stimulus therefore rewrites the ratio from 4.5 to 2.5 while the divider is running, timestamps every rising edge for more than a microsecond, and requires each recorded interval to be one of the two legal periods. A monitor of edge-to-edge spacing stays active for the whole run. It covers the source switch and the gate being turned off and on again, which together exercise the select handshake and the falling-edge gate.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_GATE = 1'b1;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hdiv_rst_sync.sv
`timescale 1ns/1ps
module hdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_sync_n <= stage1;
    end
  end
endmodule

// File: rtl/hdiv_regs.sv
`timescale 1ns/1ps
module hdiv_regs
  import hdiv_pkg::*;
#(
  parameter int NUM_SRC   = 2,
  parameter int SEL_W     = 1,
  parameter int SEL_SHIFT = 8,
  parameter int DIV_W     = 4,
  parameter int DIV_SHIFT = 0,
  parameter int GATE_BIT  = 3,
  parameter bit HIWORD    = 1'b1,
  parameter bit SEL_RO    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic [SEL_W-1:0] sel_q,
  output logic [DIV_W-1:0] div_q,
  output logic             gate_q
);
  localparam bit SEL_WRITABLE = (SEL_RO == 1'b0) && (NUM_SRC > 1);

  logic [BUS_W-1:0] ctrl_img, gate_img, wmask, ctrl_new, gate_new;
  logic [SEL_W-1:0] sel_d;
  logic [DIV_W-1:0] div_d;
  logic             gate_d;
  logic             wr_ctrl, wr_gate;

  always_comb begin
    ctrl_img = '0;
    ctrl_img[SEL_SHIFT +: SEL_W] = sel_q;
    ctrl_img[DIV_SHIFT +: DIV_W] = div_q;
    gate_img = '0;
    gate_img[GATE_BIT] = gate_q;
    wmask    = HIWORD ? {{HALF_W{1'b0}}, wr_data[BUS_W-1:HALF_W]} : {BUS_W{1'b1}};
    ctrl_new = (ctrl_img & ~wmask) | (wr_data & wmask);
    gate_new = (gate_img & ~wmask) | (wr_data & wmask);
    wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    wr_gate  = wr_en && (wr_addr == ADDR_GATE);
    sel_d    = (wr_ctrl && SEL_WRITABLE) ? ctrl_new[SEL_SHIFT +: SEL_W] : sel_q;
    div_d    = wr_ctrl ? ctrl_new[DIV_SHIFT +: DIV_W] : div_q;
    gate_d   = wr_gate ? gate_new[GATE_BIT] : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      div_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      div_q  <= div_d;
      gate_q <= gate_d;
    end
  end

  assign rd_data = (rd_addr == ADDR_GATE) ? gate_img : ctrl_img;
endmodule

// File: rtl/hdiv_mux.sv
`timescale 1ns/1ps
module hdiv_mux #(
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = 1
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_SRC-1:0] src_rst_n,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SRC-1:0] src_en,
  output logic               clk_mux
);
  if (NUM_SRC == 1) begin : g_single
    assign src_en  = 1'b1;
    assign clk_mux = src_clk[0];
  end else begin : g_multi
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic req, stg, en_r;

      // request only once every other source has let go
      always_comb begin
        req = (sel == SEL_W'(i)) && !(|(src_en & ~(NUM_SRC'(1) << i)));
      end

      always_ff @(posedge src_clk[i] or negedge src_rst_n[i]) begin
        if (!src_rst_n[i]) stg <= 1'b0;
        else               stg <= req;
      end

      // enable moves while this source is low
      always_ff @(negedge src_clk[i] or negedge src_rst_n[i]) begin
        if (!src_rst_n[i]) en_r <= 1'b0;
        else               en_r <= stg;
      end

      assign src_en[i] = en_r;
    end
    assign clk_mux = |(src_clk & src_en);
  end
endmodule

// File: rtl/hdiv_gate.sv
`timescale 1ns/1ps
module hdiv_gate (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en,
  output logic clk_out
);
  logic en_s1, en_lo;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) en_s1 <= 1'b0;
    else        en_s1 <= en;
  end

  // enable changes only while the input clock is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_lo <= 1'b0;
    else        en_lo <= en_s1;
  end

  assign clk_out = clk_in & en_lo;
endmodule

// File: rtl/hdiv_core.sv
`timescale 1ns/1ps
module hdiv_core #(
  parameter int DIV_W = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             clk_out
);
  localparam int CW = DIV_W + 3;

  logic [DIV_W-1:0] v_s1, v_s2, v_act, v_act_d;
  logic [CW-1:0]    cnt, cnt_d, vx, last, hi_len, mid, fall2, twice, twice1;
  logic             wrap, p_hit, n_hit, tp, tp_d, nh, tn;

  // One lap of cnt spans 2v+3 input cycles, which is two output periods.
  // Toggle points in half-cycles: 0, v+2, 2v+3, 3v+5.
  always_comb begin
    vx      = {3'b000, v_act};
    last    = (vx << 1) + CW'(2);
    hi_len  = vx + CW'(2);
    mid     = (vx << 1) + CW'(3);
    fall2   = vx + (vx << 1) + CW'(5);
    twice   = cnt << 1;
    twice1  = twice + CW'(1);
    wrap    = (cnt == last);
    cnt_d   = wrap ? '0 : cnt + CW'(1);
    v_act_d = (wrap && (v_s1 == v_s2)) ? v_s2 : v_act;
    p_hit   = (cnt == '0) || (twice == hi_len) || (twice == fall2);
    n_hit   = (twice1 == hi_len) || (twice1 == mid) || (twice1 == fall2);
    tp_d    = tp ^ p_hit;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      v_s1  <= '0;
      v_s2  <= '0;
      v_act <= '0;
      cnt   <= '0;
      tp    <= 1'b0;
      nh    <= 1'b0;
    end else begin
      v_s1  <= div_val;
      v_s2  <= v_s1;
      v_act <= v_act_d;
      cnt   <= cnt_d;
      tp    <= tp_d;
      nh    <= n_hit;
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) tn <= 1'b0;
    else        tn <= tn ^ nh;
  end

  assign clk_out = tp ^ tn;
endmodule

// File: rtl/hdiv_branch.sv
`timescale 1ns/1ps
module hdiv_branch
  import hdiv_pkg::*;
#(
  parameter int NUM_SRC   = 2,
  parameter int SEL_SHIFT = 8,
  parameter int DIV_W     = 4,
  parameter int DIV_SHIFT = 0,
  parameter int GATE_BIT  = 3,
  parameter bit HIWORD    = 1'b1,
  parameter bit SEL_RO    = 1'b0,
  parameter bit HAS_GATE  = 1'b1,
  parameter bit HAS_DIV   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               clk_out
);
  localparam int SEL_W = sel_width(NUM_SRC);

  logic               rst_bus_n;
  logic [NUM_SRC-1:0] src_rst_n;
  logic [NUM_SRC-1:0] src_en;
  logic [SEL_W-1:0]   sel_q;
  logic [DIV_W-1:0]   div_q;
  logic               gate_q;
  logic               clk_mux, clk_gated;

  hdiv_rst_sync u_rst_bus (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_bus_n));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_rst
    hdiv_rst_sync u_rst_src (.clk(src_clk[i]), .rst_n(rst_n), .rst_sync_n(src_rst_n[i]));
  end

  hdiv_regs #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SEL_SHIFT(SEL_SHIFT), .DIV_W(DIV_W),
    .DIV_SHIFT(DIV_SHIFT), .GATE_BIT(GATE_BIT), .HIWORD(HIWORD), .SEL_RO(SEL_RO)
  ) u_regs (
    .clk(clk), .rst_n(rst_bus_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_q(sel_q), .div_q(div_q), .gate_q(gate_q)
  );

  hdiv_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .sel(sel_q),
    .src_en(src_en), .clk_mux(clk_mux)
  );

  if (HAS_GATE) begin : g_gate
    logic rst_mux_n;
    hdiv_rst_sync u_rst_mux (.clk(clk_mux), .rst_n(rst_n), .rst_sync_n(rst_mux_n));
    hdiv_gate u_gate (.clk_in(clk_mux), .rst_n(rst_mux_n), .en(gate_q), .clk_out(clk_gated));
  end else begin : g_nogate
    assign clk_gated = clk_mux;
  end

  if (HAS_DIV) begin : g_div
    logic rst_div_n;
    hdiv_rst_sync u_rst_div (.clk(clk_gated), .rst_n(rst_n), .rst_sync_n(rst_div_n));
    hdiv_core #(.DIV_W(DIV_W)) u_core (
      .clk_in(clk_gated), .rst_n(rst_div_n), .div_val(div_q), .clk_out(clk_out)
    );
  end else begin : g_nodiv
    assign clk_out = clk_gated;
  end
endmodule

// File: rtl/hdiv_branch_chk.sv
`timescale 1ns/1ps
module hdiv_branch_chk #(
  parameter int NUM_SRC   = 2,
  parameter int SEL_W     = 1,
  parameter int DIV_W     = 4,
  parameter int DIV_SHIFT = 0,
  parameter bit HIWORD    = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_addr,
  input logic [31:0]        wr_data,
  input logic [NUM_SRC-1:0] src_en,
  input logic [SEL_W-1:0]   sel_q,
  input logic [DIV_W-1:0]   div_q
);
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_en)); // R7

  AST_GATE_ADDR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> ($stable(div_q) && $stable(sel_q))); // R4

  if (HIWORD) begin : g_hw
    AST_MASKED_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && (wr_data[16+DIV_SHIFT +: DIV_W] == '0)) |=> $stable(div_q)); // R4
  end
endmodule

module hdiv_core_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic [DIV_W+2:0] cnt,
  input logic [DIV_W-1:0] v_act,
  input logic             clk_out
);
  AST_CNT_IN_LAP: assert property (@(posedge clk_in) disable iff (!rst_n)
    int'(cnt) <= 2 * int'(v_act) + 2); // R2

  AST_LAP_STARTS_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt == '0) |-> (clk_out == 1'b0)); // R3

  AST_RATIO_HELD_MIDLAP: assert property (@(posedge clk_in) disable iff (!rst_n)
    (int'(cnt) != 2 * int'(v_act) + 2) |=> $stable(v_act)); // R8
endmodule

bind hdiv_branch hdiv_branch_chk #(
  .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .HIWORD(HIWORD)
) u_branch_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .src_en(src_en), .sel_q(sel_q), .div_q(div_q)
);

bind hdiv_core hdiv_core_chk #(.DIV_W(DIV_W)) u_core_chk (
  .clk_in(clk_in), .rst_n(rst_n), .cnt(cnt), .v_act(v_act), .clk_out(clk_out)
);

// File: tb/sim_hdiv_branch.sv
`timescale 1ns/1ps
module sim_hdiv_branch;
  localparam logic [31:0] CTRL_IMPL = 32'h0000_010F;
  localparam logic [31:0] GATE_IMPL = 32'h0000_0008;
  localparam logic [31:0] SEL_BIT   = 32'h0000_0100;
  localparam real T0 = 8.0;
  localparam real T1 = 12.0;

  logic        clk, rst_n, wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data, rd0, rd1;
  logic [1:0]  src;
  logic        out0, out1, msel, mclk;

  integer checks = 0;
  integer failures = 0;
  logic [31:0] mc, mg;

  hdiv_branch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd0), .src_clk(src), .clk_out(out0)
  );

  hdiv_branch #(.SEL_RO(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd1), .src_clk(src), .clk_out(out1)
  );

  assign mclk = msel ? out1 : out0;

  initial begin clk = 1'b0; forever #5 clk = ~clk; end
  initial begin src[0] = 1'b0; forever #4 src[0] = ~src[0]; end
  initial begin src[1] = 1'b0; forever #6 src[1] = ~src[1]; end

  // edge and pulse-width monitor on u0
  integer edges = 0;
  real    last_edge = -1.0;
  real    minp = 1.0e9;
  always @(out0) begin
    if (last_edge >= 0.0 && ($realtime - last_edge) < minp) minp = $realtime - last_edge;
    last_edge = $realtime;
    edges = edges + 1;
  end

  // period recorder on u0 rising edges
  logic rec = 1'b0;
  real  last_rise = -1.0;
  real  perq[$];
  always @(posedge out0) begin
    if (rec && last_rise >= 0.0) perq.push_back($realtime - last_rise);
    last_rise = $realtime;
  end

  // register model compared every clock on both instances
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      checks = checks + 2;
      if (rd0 !== (rd_addr ? mg : mc)) begin
        failures = failures + 1;
        $display("FAIL R4 u0 rd addr=%0d actual=%h expected=%h", rd_addr, rd0, rd_addr ? mg : mc);
      end
      if (rd1 !== (rd_addr ? mg : (mc & ~SEL_BIT))) begin
        failures = failures + 1;
        $display("FAIL R9 u1 rd addr=%0d actual=%h expected=%h", rd_addr, rd1,
                 rd_addr ? mg : (mc & ~SEL_BIT));
      end
    end
  end

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic chk_int(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_real(input string tag, input real act, input real exp);
    checks = checks + 1;
    if (!near(act, exp)) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    logic [31:0] m;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    m = {16'h0000, d[31:16]};
    if (a) mg = ((mg & ~m) | (d & m)) & GATE_IMPL;
    else   mc = ((mc & ~m) | (d & m)) & CTRL_IMPL;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #2;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic settle();
    repeat (200) @(posedge clk);
  endtask

  task automatic measure(input logic which, output real per, output real hi);
    real t0, t1, t2;
    msel = which;
    #1;
    @(posedge mclk); @(posedge mclk);
    t0 = $realtime;
    @(negedge mclk);
    t1 = $realtime;
    @(posedge mclk);
    t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  initial begin
    #1500000;
    failures = failures + 1;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1;
    real per, hi;
    bit  ok;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    msel = 1'b0; mc = '0; mg = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // R1 reset state
    rd(1'b0, a0, a1);
    chk_int(a0 == 32'h0, "R1 ctrl after reset", a0, 0);
    rd(1'b1, a0, a1);
    chk_int(a0 == 32'h0, "R1 gate after reset", a0, 0);
    edges = 0;
    repeat (50) @(posedge clk);
    chk_int(edges == 0, "R1 no output edges while gated", edges, 0);

    // R6 enable gate, R2/R3 at v=0 on source 0
    wr(1'b1, 32'h0008_0008);
    rd(1'b1, a0, a1);
    chk_int(a0 == 32'h8, "R6 gate readback", a0, 8);
    settle();
    measure(1'b0, per, hi);
    chk_real("R2 period v=0 src0", per, 1.5 * T0);
    chk_real("R3 high v=0 src0", hi, 2.0 * T0 / 2.0);

    wr(1'b0, 32'h000F_0003);
    settle();
    measure(1'b0, per, hi);
    chk_real("R2 period v=3 src0", per, 4.5 * T0);
    chk_real("R3 high v=3 src0", hi, 5.0 * T0 / 2.0);

    // R8 ratio change while running
    perq.delete();
    rec = 1'b1;
    wr(1'b0, 32'h000F_0001);
    repeat (150) @(posedge clk);
    rec = 1'b0;
    ok = (perq.size() > 3);
    foreach (perq[k]) if (!near(perq[k], 4.5 * T0) && !near(perq[k], 2.5 * T0)) ok = 1'b0;
    if (perq.size() > 0 && !near(perq[perq.size()-1], 2.5 * T0)) ok = 1'b0;
    chk_int(ok, "R8 periods only old or new", perq.size(), 0);

    // R4 mask clear: nothing changes
    wr(1'b0, 32'h0000_0107);
    rd(1'b0, a0, a1);
    chk_int(a0 == 32'h1, "R4 unmasked write ignored", a0, 1);
    measure(1'b0, per, hi);
    chk_real("R4 period unchanged v=1", per, 2.5 * T0);

    // R4 partial mask + R5 select source 1
    wr(1'b0, 32'h0100_0100);
    rd(1'b0, a0, a1);
    chk_int(a0 == 32'h101, "R4 partial mask keeps divider", a0, 32'h101);
    chk_int(a1 == 32'h001, "R9 read-only select ignores write", a1, 1);
    settle();
    measure(1'b0, per, hi);
    chk_real("R5 period v=1 src1", per, 2.5 * T1);
    chk_real("R3 high v=1 src1", hi, 3.0 * T1 / 2.0);
    measure(1'b1, per, hi);
    chk_real("R9 ro instance stays on src0", per, 2.5 * T0);

    // R2 largest value
    wr(1'b0, 32'h000F_000F);
    settle();
    measure(1'b0, per, hi);
    chk_real("R2 period v=15 src1", per, 16.5 * T1);
    chk_real("R3 high v=15 src1", hi, 17.0 * T1 / 2.0);
    measure(1'b1, per, hi);
    chk_real("R2 period v=15 src0 ro instance", per, 16.5 * T0);

    // R6 gate off then on
    wr(1'b1, 32'h0008_0000);
    repeat (100) @(posedge clk);
    edges = 0;
    repeat (100) @(posedge clk);
    chk_int(edges == 0, "R6 output still when gated", edges, 0);
    rd(1'b1, a0, a1);
    chk_int(a0 == 32'h0, "R6 gate readback off", a0, 0);
    wr(1'b1, 32'h0008_0008);
    settle();
    measure(1'b0, per, hi);
    chk_real("R6 output resumes", per, 16.5 * T1);

    // R7 no runt pulse across the whole run
    checks = checks + 1;
    if (minp < 3.9) begin
      failures = failures + 1;
      $display("FAIL R7 shortest pulse actual=%0.3f expected>=4.000", minp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule